// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block watches a recovered DS1 receive stream and raises three level alarm flags. The stream is handed over one bit per valid cycle. Each bit comes with its position: a framing-bit marker, or a channel number and a bit-within-channel number. A separate framer supplies a per-frame boundary strobe, an out-of-frame flag, and a marker on those framing bits that carry the extended-superframe data link. Frame search, CRC checking and line decoding are done elsewhere.

The remote (yellow) alarm for superframe operation looks at the second-transmitted bit of every channel. The data-link yellow alarm looks for a run of eight ones followed by eight zeros in the data-link bits. The all-ones (AIS, blue) alarm needs two consecutive all-ones frames while the framer reports loss of frame. It is cleared by a zero anywhere in a two-frame window. Every flag is resolved at frame boundaries, so downstream logic sees stable levels for a whole frame.

Top module: `ds1_alarm_det`

## Requirements
- R1: At the end of a frame in which the bit with `bit_idx`=1 (the second-transmitted bit, channel bit 2) was 0 in all 24 channels, `yel_alarm` is 1.
- R2: At the end of a frame in which that bit was 1 in at least one channel, `yel_alarm` is 0. Zeros in other bit positions have no effect on it.
- R3: Each bit strobed with `fdl_stb` is shifted into a 16-bit history, newest at the LSB. When the history equals 16'hFF00 (eight ones, then eight zeros), `esf_yel_alarm` is 1 at the next frame end.
- R4: `esf_yel_alarm` stays 1 while matches recur within every 16 data-link bits. It is 0 at the first frame end after 16 data-link bits have passed with no match.
- R5: Framing bits without `fdl_stb`, and all channel bits, never enter the data-link history.
- R6: `ais_alarm` is set at the end of a frame when that frame and the one before it were all ones (all 193 bits) and `oof` is 1 in the `frame_stb` cycle.
- R7: `ais_alarm` is never set while `oof` is 0.
- R8: Frames are paired into two-frame windows counted from reset: frames 0 and 1, then 2 and 3, and so on. At the end of any window that contained a zero, `ais_alarm` is cleared.
- R9: After reset all three flags are 0. A flag changes only in the cycle after a `frame_stb` cycle, and `frame_stb` never coincides with `bit_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received data bit |
| fbit | input | 1 | Present bit is the frame's framing bit |
| chan_idx | input | 5 | Channel number 0..23 of a payload bit |
| bit_idx | input | 3 | Bit within channel, 0 = first transmitted |
| fdl_stb | input | 1 | Present framing bit carries the data link |
| frame_stb | input | 1 | End-of-frame strobe, one cycle, no bit that cycle |
| oof | input | 1 | Out-of-frame indication from the framer |
| yel_alarm | output | 1 | Superframe remote alarm |
| esf_yel_alarm | output | 1 | Data-link yellow alarm |
| ais_alarm | output | 1 | All-ones (blue) alarm |

## Verification
The remote alarm is swept over every channel. One frame has bit 2 clear everywhere, and the next has a single 1 in one channel, which shows that one channel is enough to clear the flag. Frames with zeros outside bit 2 show that those positions do not matter. The data-link detector gets the repeating ones/zeros pattern with zero-valued framing bits slipped in between data-link frames, and then a stuck-ones stream, which pins the exact bit count that ends the hold. The all-ones alarm gets a single zero placed at positions across the whole frame, in both halves of a window, and a stretch with `oof` low, which separates the window-aligned clear from a per-frame clear and from a set without loss of frame.

// File: rtl/ds1_alarm_pkg.sv
package ds1_alarm_pkg;
   localparam int DS1_CHANNELS = 24;
   localparam int DS1_CH_BITS  = 8;
   localparam int FDL_WIDTH    = 16;
   localparam logic [FDL_WIDTH-1:0] FDL_YEL_CODE = 16'hFF00;

   function automatic int frame_len(input int nch, input int nbits);
      return nch * nbits + 1;
   endfunction
endpackage

// File: rtl/ds1_yel_det.sv
module ds1_yel_det (
   input  logic clk,
   input  logic rst_n,
   input  logic slot_hit,
   input  logic rx_bit,
   input  logic frame_stb,
   output logic yel_o
);
   logic seen_one;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_one <= 1'b0;
         yel_o    <= 1'b0;
      end else if (frame_stb) begin
         yel_o    <= !seen_one;
         seen_one <= 1'b0;
      end else if (slot_hit && rx_bit) begin
         seen_one <= 1'b1;
      end
   end
endmodule

// File: rtl/ds1_fdl_yel_det.sv
module ds1_fdl_yel_det #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    PAT  = 16'hFF00,
   parameter int              HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fdl_bit_vld,
   input  logic rx_bit,
   input  logic frame_stb,
   output logic esf_yel_o
);
   localparam int CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

   logic [W-1:0]  hist;
   logic [W-1:0]  hist_nx;
   logic [CW-1:0] since_hit;

   assign hist_nx = {hist[W-2:0], rx_bit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist      <= '0;
         since_hit <= HOLD_C;
         esf_yel_o <= 1'b0;
      end else begin
         if (fdl_bit_vld) begin
            hist <= hist_nx;
            if (hist_nx == PAT)
               since_hit <= '0;
            else if (since_hit < HOLD_C)
               since_hit <= since_hit + 1'b1;
         end
         if (frame_stb)
            esf_yel_o <= (since_hit < HOLD_C);
      end
   end
endmodule

// File: rtl/ds1_ais_det.sv
module ds1_ais_det #(
   parameter int RUN     = 2,
   parameter int WIN     = 2,
   parameter bit USE_OOF = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic rx_bit,
   input  logic frame_stb,
   input  logic oof,
   output logic ais_o
);
   localparam int RW = $clog2(RUN + 1);
   localparam int WW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam logic [RW-1:0] RUN_C   = RW'(RUN);
   localparam logic [WW-1:0] WLAST_C = WW'(WIN - 1);

   logic          qual;
   logic          frame_zero;
   logic          win_zero;
   logic [RW-1:0] run_cnt;
   logic [RW-1:0] run_nx;
   logic [WW-1:0] win_cnt;
   logic          win_end;
   logic          win_zero_nx;

   generate
      if (USE_OOF) begin : g_oof_qual
         assign qual = oof;
      end else begin : g_no_qual
         assign qual = 1'b1;
      end
   endgenerate

   always_comb begin
      if (frame_zero)            run_nx = '0;
      else if (run_cnt == RUN_C) run_nx = RUN_C;
      else                       run_nx = run_cnt + 1'b1;
      win_end     = (win_cnt == WLAST_C);
      win_zero_nx = win_zero | frame_zero;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_zero <= 1'b0;
         win_zero   <= 1'b0;
         run_cnt    <= '0;
         win_cnt    <= '0;
         ais_o      <= 1'b0;
      end else if (frame_stb) begin
         if (win_end && win_zero_nx)
            ais_o <= 1'b0;
         else if (run_nx == RUN_C && qual)
            ais_o <= 1'b1;
         run_cnt    <= run_nx;
         win_cnt    <= win_end ? '0 : win_cnt + 1'b1;
         win_zero   <= win_end ? 1'b0 : win_zero_nx;
         frame_zero <= 1'b0;
      end else if (bit_vld && !rx_bit) begin
         frame_zero <= 1'b1;
      end
   end
endmodule

// File: rtl/ds1_alarm_det.sv
module ds1_alarm_det
   import ds1_alarm_pkg::*;
#(
   parameter int                   N_CH        = DS1_CHANNELS,
   parameter int                   CH_BITS     = DS1_CH_BITS,
   parameter int                   YEL_POS     = 1,
   parameter int                   FDL_W       = FDL_WIDTH,
   parameter logic [FDL_W-1:0]     FDL_PAT     = FDL_YEL_CODE,
   parameter int                   FDL_HOLD    = 16,
   parameter int                   AIS_RUN     = 2,
   parameter int                   AIS_WIN     = 2,
   parameter bit                   AIS_USE_OOF = 1'b1,
   localparam int                  CH_W        = $clog2(N_CH),
   localparam int                  BI_W        = $clog2(CH_BITS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bit_vld,
   input  logic            rx_bit,
   input  logic            fbit,
   input  logic [CH_W-1:0] chan_idx,
   input  logic [BI_W-1:0] bit_idx,
   input  logic            fdl_stb,
   input  logic            frame_stb,
   input  logic            oof,
   output logic            yel_alarm,
   output logic            esf_yel_alarm,
   output logic            ais_alarm
);
   localparam int FRAME_BITS = frame_len(N_CH, CH_BITS);

   generate
      if (N_CH < 2 || CH_BITS < 2) begin : g_bad_frame
         $error("ds1_alarm_det: frame of %0d bits too small", FRAME_BITS);
      end
      if (YEL_POS < 0 || YEL_POS >= CH_BITS) begin : g_bad_pos
         $error("ds1_alarm_det: YEL_POS out of range");
      end
      if (FDL_W < 2 || FDL_HOLD < 1) begin : g_bad_fdl
         $error("ds1_alarm_det: bad data-link parameters");
      end
      if (AIS_RUN < 1 || AIS_WIN < 2) begin : g_bad_ais
         $error("ds1_alarm_det: bad all-ones parameters");
      end
   endgenerate

   logic yel_slot;
   logic fdl_bit_vld;

   assign yel_slot = bit_vld && !fbit
                     && ({1'b0, chan_idx} < (CH_W+1)'(N_CH))
                     && (bit_idx == BI_W'(YEL_POS));
   assign fdl_bit_vld = bit_vld && fbit && fdl_stb;

   ds1_yel_det i_yel (
      .clk       (clk),
      .rst_n     (rst_n),
      .slot_hit  (yel_slot),
      .rx_bit    (rx_bit),
      .frame_stb (frame_stb),
      .yel_o     (yel_alarm)
   );

   ds1_fdl_yel_det #(
      .W    (FDL_W),
      .PAT  (FDL_PAT),
      .HOLD (FDL_HOLD)
   ) i_fdl (
      .clk         (clk),
      .rst_n       (rst_n),
      .fdl_bit_vld (fdl_bit_vld),
      .rx_bit      (rx_bit),
      .frame_stb   (frame_stb),
      .esf_yel_o   (esf_yel_alarm)
   );

   ds1_ais_det #(
      .RUN     (AIS_RUN),
      .WIN     (AIS_WIN),
      .USE_OOF (AIS_USE_OOF)
   ) i_ais (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_vld   (bit_vld),
      .rx_bit    (rx_bit),
      .frame_stb (frame_stb),
      .oof       (oof),
      .ais_o     (ais_alarm)
   );
endmodule

// File: rtl/ds1_alarm_det_chk.sv
module ds1_alarm_det_chk #(
   parameter bit USE_OOF = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic bit_vld,
   input logic frame_stb,
   input logic oof,
   input logic yel_alarm,
   input logic esf_yel_alarm,
   input logic ais_alarm
);
   // R9
   stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_stb && bit_vld));

   // R1 R2 R9
   yel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(yel_alarm));

   // R3 R4 R9
   esf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(esf_yel_alarm));

   // R6 R8 R9
   ais_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> $stable(ais_alarm));

   generate
      if (USE_OOF) begin : g_oof_chk
         // R7
         ais_oof_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ais_alarm) |-> $past(oof));
      end
   endgenerate
endmodule

bind ds1_alarm_det ds1_alarm_det_chk #(.USE_OOF(AIS_USE_OOF)) i_chk (.*);

// File: tb/test_ds1_alarm_det.sv
module test_ds1_alarm_det;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bit_vld, rx_bit, fbit, fdl_stb, frame_stb, oof;
   logic [4:0] chan_idx;
   logic [2:0] bit_idx;
   logic       yel_alarm, esf_yel_alarm, ais_alarm;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // bench models
   logic [15:0] sr_b;
   int          cnt_b;
   int          run_b;
   int          fno;
   bit          wz_b;
   bit          e_yel, e_esf, e_ais;

   always #10 clk = ~clk;

   ds1_alarm_det i_ds1_alarm_det (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .rx_bit(rx_bit),
      .fbit(fbit), .chan_idx(chan_idx), .bit_idx(bit_idx),
      .fdl_stb(fdl_stb), .frame_stb(frame_stb), .oof(oof),
      .yel_alarm(yel_alarm), .esf_yel_alarm(esf_yel_alarm),
      .ais_alarm(ais_alarm)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d (frame %0d)", tag, act, exp, fno);
      end
   endtask

   // yel_ch: channel with a 1 in bit 2 (-1 none) when ymode
   task automatic send_frame(input int yel_ch, input bit ymode, input int zpos,
                             input bit fdl_en, input bit fval, input bit oof_v);
      bit fz = 0;
      bit b2 = 0;
      int rn;
      bit wend;
      oof = oof_v;
      for (int p = 0; p < 193; p++) begin
         bit v = 1'b1;
         int c = 0;
         int b = 0;
         if (p == 0) begin
            fbit = 1'b1; fdl_stb = fdl_en; v = fval;
         end else begin
            c = (p - 1) / 8; b = (p - 1) % 8;
            fbit = 1'b0; fdl_stb = 1'b0;
            if (ymode && b == 1) v = (c == yel_ch);
         end
         if (p == zpos) v = 1'b0;
         if (!v) fz = 1;
         if (p > 0 && b == 1 && v) b2 = 1;
         if (p == 0 && fdl_en) begin
            sr_b = {sr_b[14:0], v};
            if (sr_b == 16'hFF00) cnt_b = 0;
            else if (cnt_b < 16) cnt_b++;
         end
         chan_idx = 5'(c); bit_idx = 3'(b); rx_bit = v; bit_vld = 1'b1;
         @(negedge clk);
      end
      bit_vld = 1'b0; fdl_stb = 1'b0; fbit = 1'b0; frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      // expected values from the requirements
      e_yel = !b2;
      e_esf = (cnt_b < 16);
      rn   = fz ? 0 : ((run_b == 2) ? 2 : run_b + 1);
      wend = (fno % 2 == 1);
      if (wend && (wz_b || fz)) e_ais = 0;
      else if (rn == 2 && oof_v) e_ais = 1;
      wz_b  = wend ? 0 : (wz_b || fz);
      run_b = rn;
      fno++;
      chk(e_yel ? "R1 yellow set" : "R2 yellow clear", yel_alarm, e_yel);
      chk("R3 R4 R5 data-link yellow", esf_yel_alarm, e_esf);
      chk("R6 R7 R8 all-ones", ais_alarm, e_ais);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL R9 watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bit_vld = 0; rx_bit = 0; fbit = 0; fdl_stb = 0;
      frame_stb = 0; oof = 0; chan_idx = 0; bit_idx = 0;
      sr_b = '0; cnt_b = 16; run_b = 0; fno = 0; wz_b = 0;
      e_yel = 0; e_esf = 0; e_ais = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 reset yellow", yel_alarm, 1'b0);
      chk("R9 reset data-link", esf_yel_alarm, 1'b0);
      chk("R9 reset all-ones", ais_alarm, 1'b0);

      // R1 R2: sweep the channel carrying the single 1
      for (int c = 0; c < 24; c++) begin
         send_frame(-1, 1, -1, 0, 1, 0);
         send_frame(c, 1, -1, 0, 1, 0);
      end
      // R2: zeros outside bit 2 leave the alarm set
      for (int k = 0; k < 8; k++)
         send_frame(-1, 1, 1 + 8 * (k * 3) + ((k % 2) ? 0 : 5), 0, 1, 0);

      // R3 R4 R5: pattern with non-link zero framing bits interleaved
      for (int rep = 0; rep < 3; rep++)
         for (int i = 0; i < 16; i++) begin
            send_frame(-1, 0, -1, 1, (i < 8), 0);
            if (i % 3 == 1) send_frame(-1, 0, -1, 0, 0, 0);
         end
      // R4: stuck ones, hold then release
      for (int i = 0; i < 20; i++) send_frame(-1, 0, -1, 1, 1, 0);

      // R6 R8: single zero moved across the frame
      for (int i = 0; i < 3; i++) send_frame(-1, 0, -1, 0, 1, 1);
      for (int p = 0; p < 193; p += 12) begin
         send_frame(-1, 0, p, 0, 1, 1);
         for (int i = 0; i < 3; i++) send_frame(-1, 0, -1, 0, 1, 1);
      end
      send_frame(-1, 0, 192, 0, 1, 1);
      for (int i = 0; i < 2; i++) send_frame(-1, 0, -1, 0, 1, 1);
      // R7: loss of frame absent, then present
      send_frame(-1, 0, 7, 0, 1, 0);
      send_frame(-1, 0, 9, 0, 1, 0);
      for (int i = 0; i < 4; i++) send_frame(-1, 0, -1, 0, 1, 0);
      for (int i = 0; i < 2; i++) send_frame(-1, 0, -1, 0, 1, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule